// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two 8-bit buses, A and B, each split into an input word, an output word and an output-enable bit. Each bus has its own holding register. A register takes a new copy of its bus when its own capture strobe goes from low to high, as seen on the system clock. Each direction also has its own select input. The select chooses whether the word sent to the far bus is the live value now on the source bus or the value held in that bus's register.

An active-low enable and a direction bit decide which bus the block drives. When the enable is low, direction high drives bus B from the A-side path. Direction low drives bus A from the B-side path. When the enable is high, neither bus is driven, but both registers keep capturing on their strobes. An undriven output reads as zero and has its enable bit low.

Both registers are cleared by a synchronous active-high reset. The strobe edge detectors are cleared by the same reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high at a clock edge, both holding registers and both strobe edge detectors clear to zero.
- R2: At a clock edge where `cap_a` is 1 and was 0 at the previous edge, the A register loads `a_in`. It keeps that value until the next such edge, even if `cap_a` stays high.
- R3: At a clock edge where `cap_b` is 1 and was 0 at the previous edge, the B register loads `b_in`. It otherwise holds its value.
- R4: When `b_oe` is 1 and `sel_ab` is 0, `b_out` equals the current `a_in` in the same cycle.
- R5: When `b_oe` is 1 and `sel_ab` is 1, `b_out` equals the A register.
- R6: When `a_oe` is 1, `a_out` equals the current `b_in` if `sel_ba` is 0, and equals the B register if `sel_ba` is 1.
- R7: With `en_n` low, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0.
- R8: With `en_n` high, `a_oe` and `b_oe` are both 0.
- R9: Captures under R2 and R3 take place whatever the values of `en_n` and `dir`.
- R10: `a_oe` and `b_oe` are never both 1.
- R11: A driven output always equals either its live source or its stored source. A change of select never yields any other word.
- R12: An output whose enable bit is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| cap_a | input | 1 | A-side capture strobe, acts on its rising edge |
| cap_b | input | 1 | B-side capture strobe, acts on its rising edge |
| a_in | input | 8 | Word read from bus A |
| a_out | output | 8 | Word driven onto bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | 8 | Word read from bus B |
| b_out | output | 8 | Word driven onto bus B |
| b_oe | output | 1 | Bus B driver enable |

## Verification
A wrong holding register is invisible until the stored path is selected and that side is enabled. When that happens it shows on the far bus in the same cycle. The bench therefore reads back each register through its stored path right after every capture, and again after strobes that are held high or that arrive while both buses are off. A wrong enable or a wrong path select shows without delay as a bad enable pair or a bad output word. The sweep covers every combination of enable, direction and both selects on several data patterns.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int unsigned XR_DEF_W = 8;

  typedef struct packed {
    logic a;
    logic b;
  } xr_oe_t;
endpackage

// File: rtl/xr_side_store.sv
module xr_side_store #(
  parameter int unsigned W = xr_pkg::XR_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic take;

  assign take = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (take) q <= d;
    end
  end

  // R1: reset clears the register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> q == '0);
  // R2 / R3: a rising strobe loads the bus word
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q) |=> q == $past(d));
  // R3 / R2: no rising strobe means the word is held
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(strobe && !strobe_q) |=> $stable(q));
endmodule

// File: rtl/xr_path_mux.sv
module xr_path_mux #(
  parameter int unsigned W = xr_pkg::XR_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  logic [W-1:0] pick;

  assign pick = sel_stored ? stored : live;
  assign out  = en ? pick : '0;

  // R11: a driven word is always one of the two legal sources
  p_no_third_value_r11: assert property (@(posedge clk) disable iff (rst)
    en |-> (out == live || out == stored));
  // R12: an idle output reads zero
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !en |-> out == '0);
endmodule

// File: rtl/xr_dir_ctrl.sv
module xr_dir_ctrl (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_n,
  input  logic           dir,
  output xr_pkg::xr_oe_t oe
);
  always_comb begin
    oe.a = ~en_n & ~dir;
    oe.b = ~en_n &  dir;
  end

  // R10: at most one bus driven
  p_single_drive_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({oe.a, oe.b}) <= 1);
  // R8: disabled means nothing driven
  p_off_when_high_r8: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (!oe.a && !oe.b));
  // R7: direction picks the driven side
  p_dir_pick_r7: assert property (@(posedge clk) disable iff (rst)
    !en_n |-> (oe.b == dir && oe.a == !dir));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int unsigned WIDTH = xr_pkg::XR_DEF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] store_a;
  logic [WIDTH-1:0] store_b;
  xr_pkg::xr_oe_t   oe;

  xr_side_store #(.W(WIDTH)) u_store_a (
    .clk(clk), .rst(rst), .strobe(cap_a), .d(a_in), .q(store_a));
  xr_side_store #(.W(WIDTH)) u_store_b (
    .clk(clk), .rst(rst), .strobe(cap_b), .d(b_in), .q(store_b));

  xr_dir_ctrl u_dir (
    .clk(clk), .rst(rst), .en_n(en_n), .dir(dir), .oe(oe));

  // toward bus B: sourced from the A side (R4, R5)
  xr_path_mux #(.W(WIDTH)) u_to_b (
    .clk(clk), .rst(rst), .en(oe.b), .sel_stored(sel_ab),
    .live(a_in), .stored(store_a), .out(b_out));
  // toward bus A: sourced from the B side (R6)
  xr_path_mux #(.W(WIDTH)) u_to_a (
    .clk(clk), .rst(rst), .en(oe.a), .sel_stored(sel_ba),
    .live(b_in), .stored(store_b), .out(a_out));

  assign a_oe = oe.a;
  assign b_oe = oe.b;

  // R9: captures proceed with both outputs off
  p_capture_while_off_r9: assert property (@(posedge clk) disable iff (rst)
    (en_n && sel_ab && $rose(cap_a)) |=> (store_a == $past(a_in)));
endmodule

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_a = 1'b0, cap_b = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out;
  logic a_oe, b_oe;
  logic [7:0] ma = '0, mb = '0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  bus_xcvr_reg dut_i (
    .clk(clk), .rst(rst), .en_n(en_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic eoa, eob;
    logic [7:0] ea, eb;
    #1;
    eob = !en_n && dir;
    eoa = !en_n && !dir;
    eb = eob ? (sel_ab ? ma : a_in) : 8'h00;
    ea = eoa ? (sel_ba ? mb : b_in) : 8'h00;
    chk({req, " R7 R8 R10 oe"}, {14'd0, a_oe, b_oe}, {14'd0, eoa, eob});
    chk({req, " R4 R5 R11 R12 b_out"}, {8'd0, b_out}, {8'd0, eb});
    chk({req, " R6 R11 R12 a_out"}, {8'd0, a_out}, {8'd0, ea});
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a_in = 8'hFF; b_in = 8'hEE;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R8 R12: idle after reset
    check_all("reset_idle");
    // R1: stored words are zero
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R1 store_a", {8'd0, b_out}, 16'h0000);
    dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R1 store_b", {8'd0, a_out}, 16'h0000);
    @(negedge clk);

    // R2: capture, then held strobe does not recapture
    a_in = 8'h5A; cap_a = 1'b1; cyc(); ma = 8'h5A;
    a_in = 8'hC3; cyc(); cyc();
    dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R2 held strobe", {8'd0, b_out}, {8'd0, ma});
    @(negedge clk); cap_a = 1'b0; cyc();
    // R3 R9: B capture with both outputs off
    en_n = 1'b1; b_in = 8'h3C; cap_b = 1'b1; cyc(); mb = 8'h3C;
    b_in = 8'h81; cyc(); cap_b = 1'b0; cyc();
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R3 R9 store_b", {8'd0, a_out}, {8'd0, mb});
    @(negedge clk);

    // sweep patterns and all control combinations
    for (int p = 0; p < 8; p++) begin
      a_in = 8'(p * 37 + 11);
      b_in = 8'(8'hA5 ^ (p * 53));
      en_n = 1'b1;
      if (p % 2 == 0) begin cap_a = 1'b1; cap_b = 1'b1; end
      else if (p % 4 == 1) cap_a = 1'b1;
      else cap_b = 1'b1;
      cyc();
      if (cap_a) ma = a_in;   // R2 R9
      if (cap_b) mb = b_in;   // R3 R9
      cap_a = 1'b0; cap_b = 1'b0;
      a_in = ~a_in; b_in = b_in + 8'd7;
      cyc();
      for (int c = 0; c < 16; c++) begin
        en_n = c[3]; dir = c[2]; sel_ab = c[1]; sel_ba = c[0];
        check_all("sweep");
        @(negedge clk);
      end
    end

    // R11: toggle select while driving bus B
    en_n = 1'b0; dir = 1'b1;
    for (int t = 0; t < 4; t++) begin
      sel_ab = t[0];
      check_all("R11 toggle");
      @(negedge clk);
    end

    // R1: reset again clears both
    rst = 1'b1; cyc(); rst = 1'b0; ma = '0; mb = '0;
    sel_ab = 1'b1; dir = 1'b1;
    #1 chk("R1 re-reset a", {8'd0, b_out}, 16'h0000);
    dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R1 re-reset b", {8'd0, a_out}, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule